// File: doc/BRIEF.md
# Control-Line Ripple-Carry ALU

This block is a purely combinational arithmetic and logic unit of parameterised width. It has no opcode. Five raw control lines reshape a single ripple-carry adder: two operand inverters, a carry into the lowest bit, an override that turns each bit's first-stage XOR into an OR, and an override that forces the carry into every bit to 1. Combinations of these lines give addition, two's-complement subtraction, OR, NOR, AND, NAND, XOR and XNOR.

Each bit is a full adder made of two half adders. Each half adder is an XOR for the sum and an AND for the carry. The operand inverters XOR every operand bit with their control line before the adder. The block has no clock and no reset. The caller drives operands and control lines and then reads the result and carry-out.

Top module: `rca_ctrl_alu`

## Requirements
- R1: With every control line low, {carry_o, result_o} equals a_i + b_i. Example: with WIDTH=4, 0b1101 + 0b0101 gives result 0b0010 and carry-out 1.
- R2: With inv_b_i and carry_in_i high and the other lines low, result_o equals a_i - b_i modulo 2^WIDTH. carry_o is 1 exactly when a_i >= b_i. Example: with WIDTH=4, 0b1100 - 0b1001 gives 0b0011.
- R3: inv_a_i and inv_b_i each complement every bit of their operand before it reaches the adder. Without the OR and flood lines, {carry_o, result_o} equals A' + B' + carry_in_i, where A' and B' are the conditioned operands.
- R4: With or_mode_i high and flood_i low, carry_o is 0 and no carry passes between bits. result_o equals (A' | B') XOR carry_in_i, where carry_in_i acts on bit 0 only.
- R5: With flood_i high and or_mode_i low, result_o equals the bitwise XNOR of A' and B', and carry_o is 0 whatever carry_in_i is. Example: with WIDTH=4, 0b0111 and 0b1111 give 0b0111.
- R6: With both or_mode_i and flood_i high, result_o equals the bitwise NOR of A' and B', and carry_o is 0. With both inverters also high, this gives a_i AND b_i.
- R7: With inv_a_i, inv_b_i and or_mode_i high, flood_i low and carry_in_i low, result_o equals a_i NAND b_i. Example: with WIDTH=4, 0b1011 and 0b0110 give 0b1101. With only or_mode_i high, 0b1100 and 0b0101 give 0b1101.
- R8: With inv_a_i and flood_i high and the other lines low, result_o equals a_i XOR b_i.
- R9: With all inputs at zero, result_o and carry_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| inv_a_i | input | 1 | Complement operand A before the adder |
| inv_b_i | input | 1 | Complement operand B before the adder |
| carry_in_i | input | 1 | Carry into bit 0 |
| or_mode_i | input | 1 | Turn each bit's first XOR into an OR and kill the ripple carries |
| flood_i | input | 1 | Force the carry into every bit to 1 |
| result_o | output | WIDTH | Result |
| carry_o | output | 1 | Carry out of the top bit (0 in OR or flood mode) |

## Verification
At width 4, every operand pair is applied under all 32 control combinations. This separates a true ripple (long carry chains such as 0b1111 + 0b0001) from a per-bit XOR. It also shows that the OR override really kills the chain, and that the flood override ignores both the chain and carry_in_i. At width 8, random operands under every control combination catch faults that appear only at the full width. Named vectors reproduce the worked examples: subtract, overflow add, OR, NAND and XNOR.

// File: rtl/alu_ctl_pkg.sv
// Package: shared control-line bundle for the ripple ALU.
// Assumes: all fields are active-high, independent single bits.
package alu_ctl_pkg;

    typedef struct packed {
        logic inv_a;     // complement operand A
        logic inv_b;     // complement operand B
        logic carry_in;  // carry into bit 0
        logic or_mode;   // first-stage XOR becomes OR, ripple killed
        logic flood;     // carry into every bit forced to 1
    } alu_ctl_t;

endpackage

// File: rtl/alu_half_add.sv
// Module: one half adder, XOR for sum and AND for carry.
// Assumes: single-bit inputs, purely combinational.
module alu_half_add (
    input  logic x_i,
    input  logic y_i,
    output logic s_o,
    output logic c_o
);
    // Sum and carry of two bits.
    always_comb begin
        s_o = x_i ^ y_i;
        c_o = x_i & y_i;
    end
endmodule

// File: rtl/alu_operand_cond.sv
// Module: conditionally complements an operand by XOR with a control line.
// Assumes: WIDTH >= 1; the control bit applies to every bit alike.
module alu_operand_cond #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] d_i,
    input  logic             inv_i,
    output logic [WIDTH-1:0] q_o
);
    // XOR each bit with the inversion control.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            q_o[i] = d_i[i] ^ inv_i;
        end
    end

    // R3: an asserted inversion yields the complement; otherwise a pass-through.
    always_comb begin
        a_r3_invert: assert (q_o == (inv_i ? ~d_i : d_i))
            else $error("a_r3_invert: conditioned operand wrong");
    end
endmodule

// File: rtl/alu_bit_slice.sv
// Module: one ALU bit, a full adder built from two half adders with an
//         XOR-to-OR override on the first stage and a carry-flood override
//         on the carry input.
// Assumes: operands are already conditioned by the inverters.
module alu_bit_slice (
    input  logic a_i,
    input  logic b_i,
    input  logic cin_i,
    input  logic or_mode_i,
    input  logic flood_i,
    output logic sum_o,
    output logic cout_o
);
    logic x1, g1;      // first half adder outputs
    logic p1;          // first-stage propagate (XOR, or OR when overridden)
    logic g1_eff;      // first-stage generate after the OR override
    logic cin_eff;     // carry seen by this bit after the flood override
    logic g2;          // second half adder carry: p1 AND cin_eff

    alu_half_add u_ha1 (.x_i(a_i), .y_i(b_i), .s_o(x1), .c_o(g1));

    // Override the first stage: OR mode lets the both-ones case through.
    always_comb begin
        p1      = x1 | (or_mode_i & g1);
        g1_eff  = g1 & ~or_mode_i;
        cin_eff = cin_i | flood_i;
    end

    alu_half_add u_ha2 (.x_i(p1), .y_i(cin_eff), .s_o(sum_o), .c_o(g2));

    // Carry leaving the bit; killed in OR mode and in flood mode.
    always_comb begin
        cout_o = ~or_mode_i & ~flood_i & (g1_eff | g2);
    end

    // Assertions relating the slice ports.
    always_comb begin
        // R1: plain mode behaves as a full adder.
        if (!or_mode_i && !flood_i) begin
            a_r1_full_add: assert ({cout_o, sum_o} == 2'(a_i + b_i + cin_i))
                else $error("a_r1_full_add: bit sum wrong");
        end
        // R4: no carry leaves a bit in OR mode.
        if (or_mode_i) begin
            a_r4_or_no_carry: assert (cout_o == 1'b0)
                else $error("a_r4_or_no_carry: carry escaped");
        end
        // R5: flood without OR gives XNOR of the bit operands.
        if (flood_i && !or_mode_i) begin
            a_r5_flood_xnor: assert (sum_o == ~(a_i ^ b_i))
                else $error("a_r5_flood_xnor: flooded bit wrong");
        end
        // R6: flood with OR gives NOR of the bit operands.
        if (flood_i && or_mode_i) begin
            a_r6_flood_nor: assert (sum_o == ~(a_i | b_i))
                else $error("a_r6_flood_nor: NOR bit wrong");
        end
    end
endmodule

// File: rtl/rca_ctrl_alu.sv
// Module: top of the control-line ripple-carry ALU. Conditions both
//         operands, then ripples a carry through WIDTH bit slices.
// Assumes: purely combinational; the caller holds inputs stable while
//          reading the outputs. No clock or reset exists.
module rca_ctrl_alu #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             inv_a_i,
    input  logic             inv_b_i,
    input  logic             carry_in_i,
    input  logic             or_mode_i,
    input  logic             flood_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);
    import alu_ctl_pkg::*;

    localparam int CHAIN = WIDTH + 1;

    alu_ctl_t         ctl;
    logic [WIDTH-1:0] a_c, b_c;
    logic [CHAIN-1:0] chain;

    // Gather the raw control lines into one bundle.
    always_comb begin
        ctl.inv_a    = inv_a_i;
        ctl.inv_b    = inv_b_i;
        ctl.carry_in = carry_in_i;
        ctl.or_mode  = or_mode_i;
        ctl.flood    = flood_i;
    end

    alu_operand_cond #(.WIDTH(WIDTH)) u_cond_a (.d_i(a_i), .inv_i(ctl.inv_a), .q_o(a_c));
    alu_operand_cond #(.WIDTH(WIDTH)) u_cond_b (.d_i(b_i), .inv_i(ctl.inv_b), .q_o(b_c));

    assign chain[0] = ctl.carry_in;

    // One slice per bit; each slice feeds the carry of the next.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        alu_bit_slice u_slice (
            .a_i      (a_c[i]),
            .b_i      (b_c[i]),
            .cin_i    (chain[i]),
            .or_mode_i(ctl.or_mode),
            .flood_i  (ctl.flood),
            .sum_o    (result_o[i]),
            .cout_o   (chain[i+1])
        );
    end

    // The carry-out is the carry leaving the top slice.
    assign carry_o = chain[CHAIN-1];

    // Whole-word checks at the top-level ports.
    always_comb begin
        // R5 / R6: the flood line never produces a carry-out.
        if (flood_i) begin
            a_r5_flood_cout: assert (carry_o == 1'b0)
                else $error("a_r5_flood_cout: carry-out in flood mode");
        end
        // R4: the OR mode never produces a carry-out.
        if (or_mode_i) begin
            a_r4_or_cout: assert (carry_o == 1'b0)
                else $error("a_r4_or_cout: carry-out in OR mode");
        end
    end
endmodule

// File: tb/sim_rca_ctrl_alu.sv
// Bench: exhaustive sweep at width 4 and random sweep at width 8, with
//        expected values computed arithmetically from the requirements.
module sim_rca_ctrl_alu;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0] a4, b4, r4;
    logic [7:0] a8, b8, r8;
    logic [4:0] c4, c8;     // {flood, or_mode, carry_in, inv_b, inv_a}
    logic       co4, co8;

    rca_ctrl_alu #(.WIDTH(4)) u0 (
        .a_i(a4), .b_i(b4), .inv_a_i(c4[0]), .inv_b_i(c4[1]),
        .carry_in_i(c4[2]), .or_mode_i(c4[3]), .flood_i(c4[4]),
        .result_o(r4), .carry_o(co4));

    rca_ctrl_alu #(.WIDTH(8)) u1 (
        .a_i(a8), .b_i(b8), .inv_a_i(c8[0]), .inv_b_i(c8[1]),
        .carry_in_i(c8[2]), .or_mode_i(c8[3]), .flood_i(c8[4]),
        .result_o(r8), .carry_o(co8));

    // Expected {carry, result} at width n from the requirement text.
    function automatic logic [8:0] model(int n, logic [7:0] a, logic [7:0] b, logic [4:0] c);
        logic [8:0] mask, ac, bc, s;
        mask = (9'd1 << n) - 9'd1;
        ac = {1'b0, a ^ {8{c[0]}}} & mask;
        bc = {1'b0, b ^ {8{c[1]}}} & mask;
        if (c[4] && c[3])      s = ~(ac | bc) & mask;               // R6
        else if (c[4])         s = ~(ac ^ bc) & mask;               // R5
        else if (c[3])         s = ((ac | bc) ^ {8'd0, c[2]}) & mask; // R4
        else begin
            s = ac + bc + {8'd0, c[2]};                              // R1 / R3
            s = (s & mask) | ({8'd0, s[n]} << n);
        end
        return s;
    endfunction

    function automatic string tag_of(logic [4:0] c);
        if (c[4] && c[3]) return "R6";
        if (c[4])         return "R5";
        if (c[3])         return "R4";
        if (c == 5'b00110) return "R2";
        if (c[0] || c[1]) return "R3";
        return "R1";
    endfunction

    task automatic cmp(string tag, logic [8:0] got, logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Drive width-4 inputs, sample on the falling edge, compare.
    task automatic run4(string tag, logic [3:0] a, logic [3:0] b, logic [4:0] c, logic [8:0] exp);
        @(posedge clk);
        a4 = a; b4 = b; c4 = c;
        @(negedge clk);
        cmp(tag, {4'd0, co4, r4}, exp);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog got=hang exp=done");
        finish_run();
    end

    initial begin
        a4 = '0; b4 = '0; c4 = '0;
        a8 = '0; b8 = '0; c8 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: all-zero inputs give zero outputs.
        cmp("R9", {4'd0, co4, r4}, 9'd0);
        cmp("R9", {co8, r8}, 9'd0);

        // Worked examples (width 4).
        run4("R1", 4'b1101, 4'b0101, 5'b00000, 9'b1_0010);
        run4("R2", 4'b1100, 4'b1001, 5'b00110, 9'b1_0011);
        run4("R7", 4'b1100, 4'b0101, 5'b01000, 9'b0_1101);
        run4("R7", 4'b1011, 4'b0110, 5'b01011, 9'b0_1101);
        run4("R5", 4'b0111, 4'b1111, 5'b10000, 9'b0_0111);
        run4("R5", 4'b0111, 4'b1111, 5'b10100, 9'b0_0111);  // carry_in ignored
        run4("R6", 4'b1100, 4'b1010, 5'b11011, 9'b0_1000);  // AND
        run4("R8", 4'b1100, 4'b1010, 5'b10001, 9'b0_0110);  // XOR
        run4("R4", 4'b1111, 4'b0001, 5'b01100, 9'b0_1110);  // no ripple
        run4("R1", 4'b1111, 4'b0001, 5'b00000, 9'b1_0000);  // full ripple

        // Exhaustive sweep at width 4.
        for (int c = 0; c < 32; c++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    run4(tag_of(5'(c)), 4'(a), 4'(b), 5'(c),
                         model(4, 8'(a), 8'(b), 5'(c)));
                end
            end
        end

        // Random sweep at width 8 under every control combination.
        for (int k = 0; k < 2048; k++) begin
            logic [4:0] cc;
            cc = 5'(k % 32);
            @(posedge clk);
            a8 = 8'($urandom); b8 = 8'($urandom); c8 = cc;
            @(negedge clk);
            cmp(tag_of(cc), {co8, r8}, model(8, a8, b8, cc));
        end

        finish_run();
    end
endmodule